// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of the finite field GF(2^12). The field is built as a quadratic extension of GF(2^6). Each operand is treated as a pair of 6-bit base-field digits, and the product is assembled from three base-field products. The multiply path is purely combinational.

A second, sequential path holds a 12-bit power register. Each enabled clock multiplies that register by a fixed step constant. The register therefore walks through the powers of that constant, one per cycle. A log/antilog table builder can record each value as it appears.

The block holds neither table storage nor any decoder logic.

Top module: `gf4k_tower_mul`

## Requirements
- R1: The base field is GF(64) with reduction polynomial x^6 + x + 1. The extension is GF(64)[X] modulo X^2 + X + A^-1, where A is the base-field element 0x02 and A^-1 is 0x21. An operand's bits 11:6 are its X digit (h) and bits 5:0 its constant digit (l). The high digit of `product` is m(ah^al, bh^bl) ^ m(al, bl), where m is GF(64) multiplication. The low digit is m(m(ah, bh), 0x21) ^ m(al, bl). `product` = (high << 6) ^ low, for every operand pair.
- R2: When both operands have bits 11:6 equal to zero, `product` bits 11:6 are zero and bits 5:0 equal the GF(64) product of the low digits.
- R3: If either operand is 0, `product` is 0.
- R4: The element 0x001 is the identity: a product with 0x001 on either side returns the other operand unchanged.
- R5: After reset, `power` is 0x001 and `wrap` is 0.
- R6: On a rising clock edge with `step_en` high, `power` becomes its old value times 0xE01 under R1. With `step_en` low, `power` holds its value.
- R7: `wrap` is high for exactly the one cycle after a step that returns `power` to 0x001. Starting from reset, this first happens on step 4095 and on no earlier step.
- R8: `power` is never 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the power register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 12 | First multiplicand |
| op_b | input | 12 | Second multiplicand |
| product | output | 12 | Combinational field product of op_a and op_b |
| step_en | input | 1 | Advance the power register by one step |
| power | output | 12 | Current power of the step constant |
| wrap | output | 1 | Pulses when a step brings `power` back to 0x001 |

## Verification
The hardest condition to reach is the return of `power` to 0x001. It can only occur after the full cycle of 4095 consecutive steps. The bench therefore drives `step_en` for the whole orbit. After each step it compares `power` against its own arithmetic model and confirms that `wrap` stays low until the final step. Around that walk, the multiplier is swept over all 4096 values of one operand against a spread of second operands. The sweep also covers every pair of base-field elements, which exercises the reduction branch of each digit product.

// File: rtl/gf4k_tower_mul.sv
module gf4k_tower_mul #(
  parameter int              HW        = 6,
  parameter logic [HW-1:0]   BASE_TAPS = 6'h03,
  parameter logic [HW-1:0]   ALPHA_INV = 6'h21,
  parameter logic [2*HW-1:0] STEP      = 12'hE01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*HW-1:0] op_a,
  input  logic [2*HW-1:0] op_b,
  output logic [2*HW-1:0] product,
  input  logic            step_en,
  output logic [2*HW-1:0] power,
  output logic            wrap
);
  localparam int FW = 2 * HW;
  localparam logic [FW-1:0] ONE = FW'(1);

  function automatic logic [HW-1:0] base_mul(input logic [HW-1:0] x, input logic [HW-1:0] y);
    logic [HW-1:0] acc, sh;
    acc = '0;
    sh  = x;
    for (int i = 0; i < HW; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = sh[HW-1] ? ({sh[HW-2:0], 1'b0} ^ BASE_TAPS) : {sh[HW-2:0], 1'b0};
    end
    return acc;
  endfunction

  function automatic logic [FW-1:0] ext_mul(input logic [FW-1:0] x, input logic [FW-1:0] y);
    logic [HW-1:0] xh, xl, yh, yl, ll, hi, lo;
    xh = x[FW-1:HW];
    xl = x[HW-1:0];
    yh = y[FW-1:HW];
    yl = y[HW-1:0];
    ll = base_mul(xl, yl);
    hi = base_mul(xh ^ xl, yh ^ yl) ^ ll;
    lo = base_mul(base_mul(xh, yh), ALPHA_INV) ^ ll;
    return {hi, lo};
  endfunction

  logic [FW-1:0] next_pow;

  assign product  = ext_mul(op_a, op_b);
  assign next_pow = ext_mul(power, STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      power <= ONE;
      wrap  <= 1'b0;
    end else begin
      if (step_en) power <= next_pow;
      wrap <= step_en && (next_pow == ONE);
    end
  end
endmodule

// File: rtl/gf4k_tower_mul_chk.sv
module gf4k_tower_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] op_a,
  input logic [11:0] op_b,
  input logic [11:0] product,
  input logic        step_en,
  input logic [11:0] power,
  input logic        wrap
);
  AST_SUBFIELD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (op_a[11:6] == 6'd0 && op_b[11:6] == 6'd0) |-> product[11:6] == 6'd0); // R2
  AST_ZERO_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n) (op_a == 12'd0 || op_b == 12'd0) |-> product == 12'd0); // R3
  AST_IDENTITY_A: assert property (@(posedge clk) disable iff (!rst_n) (op_a == 12'd1) |-> product == op_b); // R4
  AST_IDENTITY_B: assert property (@(posedge clk) disable iff (!rst_n) (op_b == 12'd1) |-> product == op_a); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !step_en |=> $stable(power)); // R6
  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n) step_en |=> power != $past(power)); // R6
  AST_WRAP_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n) wrap |-> power == 12'd1); // R7
  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> !wrap); // R7
  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) power != 12'd0); // R8
endmodule

bind gf4k_tower_mul gf4k_tower_mul_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .product(product),
  .step_en(step_en), .power(power), .wrap(wrap)
);

// File: tb/gf4k_tower_mul_test.sv
`timescale 1ns/1ps
module gf4k_tower_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] op_a = '0, op_b = '0;
  logic        step_en = 1'b0;
  logic [11:0] product, power;
  logic        wrap;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  gf4k_tower_mul uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .product(product),
    .step_en(step_en), .power(power), .wrap(wrap)
  );

  function automatic logic [5:0] m64(input logic [5:0] x, input logic [5:0] y);
    logic [10:0] p;
    p = '0;
    for (int i = 0; i < 6; i++) if (y[i]) p = p ^ (11'(x) << i);
    for (int i = 10; i >= 6; i--) if (p[i]) p = p ^ (11'h043 << (i - 6));
    return p[5:0];
  endfunction

  function automatic logic [11:0] m4k(input logic [11:0] x, input logic [11:0] y);
    logic [5:0] h, l;
    h = m64(x[11:6] ^ x[5:0], y[11:6] ^ y[5:0]) ^ m64(x[5:0], y[5:0]);
    l = m64(m64(x[11:6], y[11:6]), 6'h21) ^ m64(x[5:0], y[5:0]);
    return {h, l};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h)", req, act, exp, op_a, op_b);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] bset[8];
    logic [11:0] expp;
    bset = '{12'h000, 12'h001, 12'h040, 12'hE01, 12'hFFF, 12'h555, 12'hAAA, 12'h83F};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R5 power", power, 12'h001);
    chk("R5 wrap", {11'd0, wrap}, 12'd0);

    // R1 / R3 / R4 sweep over all of op_a
    for (int a = 0; a < 4096; a++) begin
      for (int k = 0; k < 8; k++) begin
        op_a = 12'(a); op_b = bset[k];
        #1;
        if (bset[k] == 12'h000) chk("R3", product, 12'h000);
        else if (bset[k] == 12'h001) chk("R4", product, op_a);
        else chk("R1", product, m4k(op_a, op_b));
      end
    end
    op_a = 12'h000; op_b = 12'h9C3; #1 chk("R3 left zero", product, 12'h000);
    op_a = 12'h001; op_b = 12'h9C3; #1 chk("R4 left one", product, 12'h9C3);

    // R2 every base-field pair
    for (int x = 0; x < 64; x++) begin
      for (int y = 0; y < 64; y++) begin
        op_a = 12'(x); op_b = 12'(y);
        #1 chk("R2", product, {6'd0, m64(6'(x), 6'(y))});
      end
    end
    op_a = 12'h020; op_b = 12'h002; #1 chk("R2 x^5*x", product, 12'h003);
    op_a = 12'h021; op_b = 12'h002; #1 chk("R1 A^-1 check", product, 12'h001);

    // R6 hold with step_en low
    @(negedge clk);
    step_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 hold", power, 12'h001);

    // R6 / R7 / R8 full orbit
    expp = 12'h001;
    for (int s = 1; s <= 4095; s++) begin
      step_en = 1'b1;
      @(negedge clk);
      expp = m4k(expp, 12'hE01);
      chk("R6 step", power, expp);
      if (power == 12'h000) chk("R8", power, 12'h001);
      chk("R7 wrap", {11'd0, wrap}, (s == 4095) ? 12'd1 : 12'd0);
    end
    step_en = 1'b0;
    @(negedge clk);
    chk("R7 pulse ends", {11'd0, wrap}, 12'd0);
    chk("R6 hold after orbit", power, 12'h001);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    chk("R6 restart", power, 12'hE01);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R5 re-reset", power, 12'h001);
    finish_run();
  end
endmodule